// File: doc/BRIEF.md
# Converter Trigger and Power Sequencer

This block decides when a data converter starts a conversion and whether the converter is powered. A mode code selects what starts a conversion: a software start strobe, a peripheral event line, or nothing at all. Each accepted trigger produces a single-cycle start pulse toward the converter. The block then waits for the converter's done handshake before it accepts the next trigger.

A sleep configuration bit removes converter power, but only when no conversion is in flight. Software polls the ready bit before it enters a low-power mode. When sleep is cleared again, power returns and a warm-up interval of (startup + 1) x 8 clock cycles runs before any conversion may begin. A trigger that arrives during warm-up is held and serviced when the interval ends. All pins are plain control and status signals; no data stream passes through the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, ready = 1, pwr_en = 1, conv_start = 0 and overrun = 0, and the block is idle with the converter powered.
- R2: With trig_mode = 1, a sw_start sampled high while idle makes conv_start high for exactly the next one cycle, and periph_evt has no effect.
- R3: With trig_mode = 7, a periph_evt sampled high while idle makes conv_start high for exactly the next one cycle, and sw_start has no effect.
- R4: With trig_mode at any value other than 1 or 7 (0 included), neither sw_start nor periph_evt produces a start pulse.
- R5: ready falls in the same cycle as conv_start rises. It stays low until conv_done is sampled high, and it is high in the cycle after that.
- R6: With trig_mode = 7, a periph_evt sampled during a conversion starts nothing. overrun is high for the one following cycle.
- R7: If trig_mode leaves 1 and 7 while a conversion runs, the conversion still completes: ready returns in the cycle after conv_done, and no further start follows.
- R8: sleep_cfg = 1 drops pwr_en in the cycle after it is sampled while idle. While a conversion runs, pwr_en stays high until the block is idle again.
- R9: While powered down with sleep_cfg = 1, ready stays 1 and triggers of either kind are ignored.
- R10: When sleep_cfg is sampled low while powered down, pwr_en rises and ready stays low for exactly (startup_cfg + 1) x 8 cycles. Without a trigger, the block is then idle.
- R11: A valid trigger sampled during warm-up produces conv_start in the cycle right after warm-up ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_mode | input | MODE_W (3) | Trigger source code: 1 = software strobe, 7 = peripheral event, others = none |
| sleep_cfg | input | 1 | Request converter power-down when idle |
| startup_cfg | input | STW (4) | Warm-up length code, (value + 1) x 8 cycles |
| sw_start | input | 1 | Software start strobe |
| periph_evt | input | 1 | Peripheral event trigger |
| conv_done | input | 1 | Converter reports the conversion finished |
| conv_start | output | 1 | One-cycle conversion start pulse |
| pwr_en | output | 1 | Converter power enable |
| ready | output | 1 | High when no conversion is pending or running |
| overrun | output | 1 | One-cycle pulse when an event is dropped during a conversion |

## Verification
The assertions take for granted that conv_done comes only while a conversion is outstanding, and never in the same cycle as the start pulse. They also take for granted that trig_mode and sleep_cfg change only between clock edges. The stimulus drives every input on the falling edge. It raises conv_done only a chosen number of cycles after a start pulse has been observed. It reprograms startup_cfg only while the block is powered down or idle.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_DOWN = 3'd0,
    ST_WARM = 3'd1,
    ST_IDLE = 3'd2,
    ST_CONV = 3'd3,
    ST_STOP = 3'd4
  } seq_state_e;

  localparam int MODE_SOFT  = 1;
  localparam int MODE_EVENT = 7;
endpackage

// File: rtl/adc_trig_select.sv
`timescale 1ns/1ps
module adc_trig_select #(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] trig_mode,
  input  logic              sw_start,
  input  logic              periph_evt,
  output logic              trig,
  output logic              mode_live,
  output logic              evt_mode
);
  import adc_seq_pkg::*;

  logic soft_mode;

  always_comb begin
    soft_mode = (trig_mode == MODE_W'(MODE_SOFT));
    evt_mode  = (trig_mode == MODE_W'(MODE_EVENT));
    mode_live = soft_mode | evt_mode;
    trig      = (soft_mode & sw_start) | (evt_mode & periph_evt);
  end
endmodule

// File: rtl/adc_warmup_timer.sv
`timescale 1ns/1ps
module adc_warmup_timer #(
  parameter int STW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           run,
  input  logic [STW-1:0] startup,
  output logic           expired
);
  localparam int CW = STW + 3;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= {startup, 3'b111};
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig,
  input  logic                    mode_live,
  input  logic                    evt_mode,
  input  logic                    periph_evt,
  input  logic                    sleep_cfg,
  input  logic                    conv_done,
  input  logic                    expired,
  output adc_seq_pkg::seq_state_e state,
  output logic                    load,
  output logic                    conv_start,
  output logic                    overrun
);
  import adc_seq_pkg::*;

  seq_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       start_q, start_d;
  logic       ovr_q, ovr_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    start_d = 1'b0;
    ovr_d   = 1'b0;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (sleep_cfg) begin
          state_d = ST_DOWN;
        end else if (trig) begin
          state_d = ST_CONV;
          start_d = 1'b1;
        end
      end
      ST_DOWN: begin
        if (!sleep_cfg) begin
          state_d = ST_WARM;
          load    = 1'b1;
          pend_d  = trig;
        end
      end
      ST_WARM: begin
        if (trig) pend_d = 1'b1;
        if (expired) begin
          if (pend_d) begin
            state_d = ST_CONV;
            start_d = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
          pend_d = 1'b0;
        end
      end
      ST_CONV: begin
        if (evt_mode && periph_evt) ovr_d = 1'b1;
        if (conv_done) state_d = ST_IDLE;
        else if (!mode_live) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (conv_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      start_q <= start_d;
      ovr_q   <= ovr_d;
    end
  end

  assign state      = state_q;
  assign conv_start = start_q;
  assign overrun    = ovr_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int MODE_W = 3,
  parameter int STW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] trig_mode,
  input  logic              sleep_cfg,
  input  logic [STW-1:0]    startup_cfg,
  input  logic              sw_start,
  input  logic              periph_evt,
  input  logic              conv_done,
  output logic              conv_start,
  output logic              pwr_en,
  output logic              ready,
  output logic              overrun
);
  import adc_seq_pkg::*;

  logic       trig, mode_live, evt_mode, load, expired;
  seq_state_e state_w;

  adc_trig_select #(.MODE_W(MODE_W)) i_sel (
    .trig_mode (trig_mode),
    .sw_start  (sw_start),
    .periph_evt(periph_evt),
    .trig      (trig),
    .mode_live (mode_live),
    .evt_mode  (evt_mode)
  );

  adc_warmup_timer #(.STW(STW)) i_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .run    (state_w == ST_WARM),
    .startup(startup_cfg),
    .expired(expired)
  );

  adc_seq_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .mode_live (mode_live),
    .evt_mode  (evt_mode),
    .periph_evt(periph_evt),
    .sleep_cfg (sleep_cfg),
    .conv_done (conv_done),
    .expired   (expired),
    .state     (state_w),
    .load      (load),
    .conv_start(conv_start),
    .overrun   (overrun)
  );

  assign pwr_en = (state_w != ST_DOWN);
  assign ready  = (state_w == ST_IDLE) || (state_w == ST_DOWN);
endmodule

// File: rtl/adc_seq_checker.sv
`timescale 1ns/1ps
module adc_seq_checker #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] trig_mode,
  input logic              sleep_cfg,
  input logic              periph_evt,
  input logic              conv_done,
  input logic              conv_start,
  input logic              pwr_en,
  input logic              ready,
  input logic              overrun,
  input logic [2:0]        state
);
  localparam logic [2:0] S_DOWN = 3'd0;
  localparam logic [2:0] S_WARM = 3'd1;
  localparam logic [2:0] S_IDLE = 3'd2;
  localparam logic [2:0] S_CONV = 3'd3;
  localparam logic [2:0] S_STOP = 3'd4;

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_ready_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !ready);

  p_ready_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && pwr_en) |-> ($past(conv_done) || $past(state) == S_WARM));

  p_start_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(state) == S_IDLE || $past(state) == S_WARM));

  p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(periph_evt) && $past(trig_mode) == MODE_W'(7)
                 && $past(state) == S_CONV));

  p_overrun_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !conv_start);

  p_down_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(state) == S_IDLE && $past(sleep_cfg)));

  p_down_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (ready && !conv_start));

  p_done_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> ((state == S_CONV || state == S_STOP) && !conv_start));
endmodule

bind adc_seq_ctrl adc_seq_checker #(.MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_mode (trig_mode),
  .sleep_cfg (sleep_cfg),
  .periph_evt(periph_evt),
  .conv_done (conv_done),
  .conv_start(conv_start),
  .pwr_en    (pwr_en),
  .ready     (ready),
  .overrun   (overrun),
  .state     (state_w)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] trig_mode = 3'd0;
  logic       sleep_cfg = 1'b0;
  logic [3:0] startup_cfg = 4'd0;
  logic       sw_start = 1'b0;
  logic       periph_evt = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_start, pwr_en, ready, overrun;

  int runs = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .sleep_cfg(sleep_cfg),
    .startup_cfg(startup_cfg), .sw_start(sw_start), .periph_evt(periph_evt),
    .conv_done(conv_done), .conv_start(conv_start), .pwr_en(pwr_en),
    .ready(ready), .overrun(overrun)
  );

  // behavioural reference: 0 down, 1 warm-up, 2 idle, 3 converting, 4 stopping
  int  m_st = 2;
  int  m_cnt = 0;
  bit  m_pend = 0;
  bit  m_start = 0;
  bit  m_ovr = 0;

  always @(posedge clk) begin
    bit t;
    t = (trig_mode == 3'd1 && sw_start) || (trig_mode == 3'd7 && periph_evt);
    m_start = 0;
    m_ovr   = 0;
    if (!rst_n) begin
      m_st = 2; m_pend = 0; m_cnt = 0;
    end else if (m_st == 2) begin
      if (sleep_cfg) m_st = 0;
      else if (t) begin m_st = 3; m_start = 1; end
    end else if (m_st == 0) begin
      if (!sleep_cfg) begin m_st = 1; m_cnt = (int'(startup_cfg) + 1) * 8; m_pend = t; end
    end else if (m_st == 1) begin
      m_cnt--;
      if (t) m_pend = 1;
      if (m_cnt == 0) begin
        if (m_pend) begin m_st = 3; m_start = 1; end
        else m_st = 2;
        m_pend = 0;
      end
    end else if (m_st == 3) begin
      if (trig_mode == 3'd7 && periph_evt) m_ovr = 1;
      if (conv_done) m_st = 2;
      else if (trig_mode != 3'd1 && trig_mode != 3'd7) m_st = 4;
    end else begin
      if (conv_done) m_st = 2;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check("R2", "model conv_start", conv_start, m_start);
      check("R5", "model ready", ready, (m_st == 2 || m_st == 0));
      check("R8", "model pwr_en", pwr_en, (m_st != 0));
      check("R6", "model overrun", overrun, m_ovr);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_conv();
    conv_done = 1'b1; tick(); conv_done = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int n;
    int k;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1", "ready", ready, 1);
    check("R1", "pwr_en", pwr_en, 1);
    check("R1", "conv_start", conv_start, 0);
    check("R1", "overrun", overrun, 0);

    // R2 software mode; event ignored
    trig_mode = 3'd1;
    periph_evt = 1'b1; tick(); periph_evt = 1'b0;
    check("R2", "event ignored in soft mode", conv_start, 0);
    sw_start = 1'b1; tick(); sw_start = 1'b0;
    check("R2", "start pulse", conv_start, 1);
    check("R5", "ready low with start", ready, 0);
    tick();
    check("R2", "pulse one cycle", conv_start, 0);
    tick(3);
    check("R5", "ready held low", ready, 0);
    finish_conv();
    check("R5", "ready after done", ready, 1);

    // R3 event mode; software strobe ignored
    trig_mode = 3'd7;
    sw_start = 1'b1; tick(); sw_start = 1'b0;
    check("R3", "strobe ignored in event mode", conv_start, 0);
    periph_evt = 1'b1; tick(); periph_evt = 1'b0;
    check("R3", "start pulse", conv_start, 1);
    tick(2);
    // R6 event during conversion
    periph_evt = 1'b1; tick(); periph_evt = 1'b0;
    check("R6", "overrun raised", overrun, 1);
    check("R6", "no extra start", conv_start, 0);
    tick();
    check("R6", "overrun one cycle", overrun, 0);
    finish_conv();
    check("R6", "ready after done", ready, 1);

    // R4 undefined modes
    for (int m = 0; m < 7; m++) begin
      if (m == 1) continue;
      trig_mode = 3'(m);
      sw_start = 1'b1; periph_evt = 1'b1; tick();
      sw_start = 1'b0; periph_evt = 1'b0;
      check("R4", "no start", conv_start, 0);
      check("R4", "still ready", ready, 1);
    end

    // R7 mode cleared during conversion
    trig_mode = 3'd1;
    sw_start = 1'b1; tick(); sw_start = 1'b0;
    trig_mode = 3'd0; tick(3);
    check("R7", "still busy", ready, 0);
    trig_mode = 3'd1; tick();
    finish_conv();
    check("R7", "ready after done", ready, 1);
    tick(2);
    check("R7", "no restart", conv_start, 0);

    // R8 sleep during conversion waits for idle
    sw_start = 1'b1; tick(); sw_start = 1'b0;
    sleep_cfg = 1'b1; tick(2);
    check("R8", "power kept while busy", pwr_en, 1);
    finish_conv();
    check("R8", "idle before power-down", pwr_en, 1);
    tick();
    check("R8", "power removed", pwr_en, 0);

    // R9 triggers ignored while down
    sw_start = 1'b1; tick(); sw_start = 1'b0;
    trig_mode = 3'd7; periph_evt = 1'b1; tick(); periph_evt = 1'b0;
    check("R9", "no start when down", conv_start, 0);
    check("R9", "ready when down", ready, 1);
    check("R9", "still down", pwr_en, 0);

    // R10 warm-up length, startup = 2 -> 24 cycles
    startup_cfg = 4'd2;
    sleep_cfg = 1'b0; tick();
    check("R10", "power back", pwr_en, 1);
    n = 0;
    while (!ready && n < 500) begin n++; tick(); end
    check("R10", "warm-up cycles", n, 24);
    check("R10", "no start after warm-up", conv_start, 0);

    // R11 trigger held during warm-up, startup = 0 -> 8 cycles
    sleep_cfg = 1'b1; tick(2);
    startup_cfg = 4'd0; trig_mode = 3'd1;
    sleep_cfg = 1'b0;
    k = 0;
    for (int j = 1; j <= 20; j++) begin
      sw_start = (j == 4);
      tick();
      if (conv_start) begin k = j; break; end
    end
    sw_start = 1'b0;
    check("R11", "held trigger start tick", k, 9);
    tick();
    finish_conv();
    check("R11", "ready after done", ready, 1);
    tick(2);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule